// File: doc/BRIEF.md
# VCO Sub-Band Lock Search Controller

This controller finds a synthesizer oscillator setting that locks for the current channel. A frequency synthesizer has three VCOs, and each VCO has eight sub-bands. Software or a higher-level sequencer supplies a starting guess and pulses `start`. The controller writes that selection to the synthesizer and waits a programmable settle time. It then samples a 3-bit tuning-voltage indicator. When the indicator reports a tuning voltage at the low end of its range, the controller moves one position down. When it reports the high end, the controller moves one position up. In both cases it writes the new selection and waits again.

The selection space is treated as one ordered walk of 24 positions. Below sub-band 0 of a VCO comes sub-band 7 of the VCO beneath it. Above sub-band 7 comes sub-band 0 of the VCO above it. The search stops at the first selection whose indicator reads locked and raises `done`. It raises `fail` in two cases: the walk would leave the ends of the space, or the indicator would send the search back the way it came. A back-and-forth walk of that kind would never settle. The chosen VCO and sub-band fields stay on the outputs after the search ends.

Top module: `vco_band_search`

## Requirements
- R1: While reset is asserted and after its release, `wrReq`, `done` and `fail` are 0, `vcoSel` is 2'b01 and `bandSel` is 3'b000.
- R2: A `start` pulse taken in an idle, done or fail state loads `initVco`/`initBand` into the selection. An `initVco` of 2'b00 is replaced by 2'b01. `wrReq` is high for exactly the one cycle after the start edge, with the new selection already on the outputs.
- R3: After each write cycle, the indicator is sampled only on the clock edge that ends the (`settleCycles`+1)-th cycle following the write cycle. Indicator values at all other times have no effect.
- R4: A sampled indicator in the range 3'b001 to 3'b110 ends the search. `done` goes high on the next cycle, no further `wrReq` is issued, and the selection is held.
- R5: A sampled indicator of 3'b000 moves the selection one sub-band down and issues a new write cycle.
- R6: A sampled indicator of 3'b111 moves the selection one sub-band up and issues a new write cycle.
- R7: Stepping down from sub-band 0 gives sub-band 7 of the VCO code one lower. Stepping up from sub-band 7 gives sub-band 0 of the VCO code one higher.
- R8: A 3'b000 sampled at VCO 2'b01 / sub-band 0, or a 3'b111 sampled at VCO 2'b11 / sub-band 7, raises `fail` instead of writing. The selection is left unchanged.
- R9: A step whose direction is opposite to the previous step of the same search raises `fail`. No write is issued.
- R10: `done` and `fail` are never high together. Each holds until the next accepted `start`. A `start` that arrives while a search is running has no effect.
- R11: `vcoSel` never shows 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search from the initial guess |
| initVco | input | 2 | Initial VCO code (00 treated as 01) |
| initBand | input | 3 | Initial sub-band |
| settleCycles | input | 16 | Wait length between a write and the indicator sample |
| lockInd | input | 3 | Tuning-voltage indicator from the synthesizer |
| vcoSel | output | 2 | VCO select field to write |
| bandSel | output | 3 | Sub-band field to write |
| wrReq | output | 1 | One-cycle request to write the selection fields |
| done | output | 1 | Search ended with lock |
| fail | output | 1 | Search ended without lock |

## Verification
The assertions check several properties on every cycle. The VCO code never reads zero, and `done` and `fail` never overlap. Every write request lasts a single cycle, and a selection change only appears together with a write request. Each rise of `done` or `fail` follows an indicator code that justifies it. The bench's scenarios are needed for the rest: the exact sampling edge after the settle count, the carry between VCOs in both directions, the edge and reversal failures, and the dropped mid-search start. The bench plant shows a false lock code until the settle window closes, so sampling on the wrong cycle gives a visibly wrong result.

// File: rtl/vbs_pkg.sv
package vbs_pkg;

  localparam int IND_W = 3;
  localparam logic [IND_W-1:0] IND_LOW  = '0;
  localparam logic [IND_W-1:0] IND_HIGH = '1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_SETTLE,
    ST_DONE,
    ST_FAIL
  } state_t;

  typedef struct packed {
    logic loadInit;
    logic loadCnt;
    logic decCnt;
    logic stepDown;
    logic stepUp;
  } strobe_t;

endpackage

// File: rtl/vbs_datapath.sv
module vbs_datapath
  import vbs_pkg::*;
#(
  parameter int VCO_W  = 2,
  parameter int BAND_W = 3,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [VCO_W-1:0]  initVco,
  input  logic [BAND_W-1:0] initBand,
  input  logic [CNT_W-1:0]  settleCycles,
  output logic [VCO_W-1:0]  vco,
  output logic [BAND_W-1:0] band,
  output logic              cntZero,
  output logic              atBottom,
  output logic              atTop,
  output logic              dirValid,
  output logic              dirUp
);

  localparam logic [VCO_W-1:0]  VCO_LO  = VCO_W'(1);
  localparam logic [VCO_W-1:0]  VCO_HI  = '1;
  localparam logic [BAND_W-1:0] BAND_LO = '0;
  localparam logic [BAND_W-1:0] BAND_HI = '1;

  logic [CNT_W-1:0] cnt;

  // selection register with carry between VCOs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vco      <= VCO_LO;
      band     <= BAND_LO;
      dirValid <= 1'b0;
      dirUp    <= 1'b0;
    end else if (strobe.loadInit) begin
      vco      <= (initVco == '0) ? VCO_LO : initVco;
      band     <= initBand;
      dirValid <= 1'b0;
      dirUp    <= 1'b0;
    end else if (strobe.stepDown) begin
      if (band == BAND_LO) begin
        band <= BAND_HI;
        vco  <= vco - VCO_W'(1);
      end else begin
        band <= band - BAND_W'(1);
      end
      dirValid <= 1'b1;
      dirUp    <= 1'b0;
    end else if (strobe.stepUp) begin
      if (band == BAND_HI) begin
        band <= BAND_LO;
        vco  <= vco + VCO_W'(1);
      end else begin
        band <= band + BAND_W'(1);
      end
      dirValid <= 1'b1;
      dirUp    <= 1'b1;
    end
  end

  // settle counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.loadCnt) begin
      cnt <= settleCycles;
    end else if (strobe.decCnt) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign cntZero  = (cnt == '0);
  assign atBottom = (vco == VCO_LO) && (band == BAND_LO);
  assign atTop    = (vco == VCO_HI) && (band == BAND_HI);

endmodule

// File: rtl/vbs_control.sv
module vbs_control
  import vbs_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [IND_W-1:0] lockInd,
  input  logic             cntZero,
  input  logic             atBottom,
  input  logic             atTop,
  input  logic             dirValid,
  input  logic             dirUp,
  output strobe_t          strobe,
  output logic             wrReq,
  output logic             done,
  output logic             fail
);

  state_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE, ST_DONE, ST_FAIL: begin
        if (start) begin
          strobe.loadInit = 1'b1;
          stateNext       = ST_WRITE;
        end
      end
      ST_WRITE: begin
        strobe.loadCnt = 1'b1;
        stateNext      = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (!cntZero) begin
          strobe.decCnt = 1'b1;
        end else if (lockInd == IND_LOW) begin
          if (atBottom || (dirValid && dirUp)) begin
            stateNext = ST_FAIL;
          end else begin
            strobe.stepDown = 1'b1;
            stateNext       = ST_WRITE;
          end
        end else if (lockInd == IND_HIGH) begin
          if (atTop || (dirValid && !dirUp)) begin
            stateNext = ST_FAIL;
          end else begin
            strobe.stepUp = 1'b1;
            stateNext     = ST_WRITE;
          end
        end else begin
          stateNext = ST_DONE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign wrReq = (state == ST_WRITE);
  assign done  = (state == ST_DONE);
  assign fail  = (state == ST_FAIL);

endmodule

// File: rtl/vco_band_search.sv
module vco_band_search
  import vbs_pkg::*;
#(
  parameter int VCO_W  = 2,
  parameter int BAND_W = 3,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [VCO_W-1:0]  initVco,
  input  logic [BAND_W-1:0] initBand,
  input  logic [CNT_W-1:0]  settleCycles,
  input  logic [IND_W-1:0]  lockInd,
  output logic [VCO_W-1:0]  vcoSel,
  output logic [BAND_W-1:0] bandSel,
  output logic              wrReq,
  output logic              done,
  output logic              fail
);

  strobe_t strobe;
  logic    cntZero, atBottom, atTop, dirValid, dirUp;

  vbs_control i_control (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .lockInd  (lockInd),
    .cntZero  (cntZero),
    .atBottom (atBottom),
    .atTop    (atTop),
    .dirValid (dirValid),
    .dirUp    (dirUp),
    .strobe   (strobe),
    .wrReq    (wrReq),
    .done     (done),
    .fail     (fail)
  );

  vbs_datapath #(
    .VCO_W  (VCO_W),
    .BAND_W (BAND_W),
    .CNT_W  (CNT_W)
  ) i_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .initVco      (initVco),
    .initBand     (initBand),
    .settleCycles (settleCycles),
    .vco          (vcoSel),
    .band         (bandSel),
    .cntZero      (cntZero),
    .atBottom     (atBottom),
    .atTop        (atTop),
    .dirValid     (dirValid),
    .dirUp        (dirUp)
  );

endmodule

// File: rtl/vbs_checker.sv
module vbs_checker #(
  parameter int VCO_W  = 2,
  parameter int BAND_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        lockInd,
  input logic [VCO_W-1:0]  vcoSel,
  input logic [BAND_W-1:0] bandSel,
  input logic              wrReq,
  input logic              done,
  input logic              fail
);

  // R11
  vco_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    vcoSel != '0);

  // R10
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(done && fail));

  // R2
  wr_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrReq |=> !wrReq);

  // R5
  sel_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((vcoSel != $past(vcoSel)) || (bandSel != $past(bandSel))) |-> wrReq);

  // R4
  done_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> ($past(lockInd) != 3'b000 && $past(lockInd) != 3'b111));

  // R8
  fail_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fail) |-> ($past(lockInd) == 3'b000 || $past(lockInd) == 3'b111));

endmodule

bind vco_band_search vbs_checker #(
  .VCO_W  (VCO_W),
  .BAND_W (BAND_W)
) i_vbs_checker (
  .clk     (clk),
  .rstN    (rstN),
  .lockInd (lockInd),
  .vcoSel  (vcoSel),
  .bandSel (bandSel),
  .wrReq   (wrReq),
  .done    (done),
  .fail    (fail)
);

// File: tb/test_vco_band_search.sv
module test_vco_band_search;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  initVco = 2'b01;
  logic [2:0]  initBand = 3'b000;
  logic [15:0] settleCycles = 16'd0;
  logic [2:0]  lockInd = 3'b011;
  logic [1:0]  vcoSel;
  logic [2:0]  bandSel;
  logic        wrReq, done, fail;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  vco_band_search i_vco_band_search (
    .clk(clk), .rstN(rstN), .start(start), .initVco(initVco), .initBand(initBand),
    .settleCycles(settleCycles), .lockInd(lockInd), .vcoSel(vcoSel), .bandSel(bandSel),
    .wrReq(wrReq), .done(done), .fail(fail)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // plant: pMode 0 target, 1 always low, 2 always high, 3 high at init then low
  int pMode = 0, pTarget = 0, pInit = 0, sinceWr = 1000000, wrCount = 0;
  always @(negedge clk) begin
    int cur;
    cycles++;
    if (wrReq) begin sinceWr = 0; wrCount++; end
    else if (sinceWr < 1000000) sinceWr++;
    cur = (int'(vcoSel) - 1) * 8 + int'(bandSel);
    if (sinceWr < int'(settleCycles) + 1) lockInd = 3'b011;  // false lock before settle
    else case (pMode)
      1: lockInd = 3'b000;
      2: lockInd = 3'b111;
      3: lockInd = (cur == pInit) ? 3'b111 : 3'b000;
      default: lockInd = (cur < pTarget) ? 3'b111 : (cur > pTarget) ? 3'b000 : 3'b101;
    endcase
  end

  // behavioural reference: 0 idle,1 write,2 settle,3 done,4 fail
  int mSt = 0, mIdx = 0, mCnt = 0, mDir = 0;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSt = 0; mIdx = 0; mCnt = 0; mDir = 0;
    end else begin
      case (mSt)
        1: begin mCnt = int'(settleCycles); mSt = 2; end
        2: begin
          if (mCnt > 0) mCnt--;
          else if (lockInd == 3'b000) begin
            if (mDir == 1 || mIdx == 0) mSt = 4;
            else begin mIdx--; mDir = -1; mSt = 1; end
          end else if (lockInd == 3'b111) begin
            if (mDir == -1 || mIdx == 23) mSt = 4;
            else begin mIdx++; mDir = 1; mSt = 1; end
          end else mSt = 3;
        end
        default: if (start) begin
          mIdx = ((initVco == 2'b00) ? 0 : int'(initVco) - 1) * 8 + int'(initBand);
          mDir = 0; mSt = 1;
        end
      endcase
    end
  end

  // cycle compare
  always @(negedge clk) begin
    if (rstN) begin
      check(wrReq == (mSt == 1), "R3 wrReq", wrReq, mSt == 1);
      check(done == (mSt == 3), "R4 done", done, mSt == 3);
      check(fail == (mSt == 4), "R8 fail", fail, mSt == 4);
      check(int'(vcoSel) == mIdx / 8 + 1, "R7 vcoSel", vcoSel, mIdx / 8 + 1);
      check(int'(bandSel) == mIdx % 8, "R5 bandSel", bandSel, mIdx % 8);
    end
  end

  bit timedOut = 0;
  task automatic runSearch(input int iv, input int ib, input int st, input int mode, input int tgt);
    @(negedge clk);
    initVco = 2'(iv); initBand = 3'(ib); settleCycles = 16'(st);
    pMode = mode; pTarget = tgt; pInit = ((iv == 0) ? 0 : iv - 1) * 8 + ib;
    wrCount = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      if (done || fail) break;
      @(negedge clk);
    end
    if (!(done || fail)) begin
      timedOut = 1;
      check(0, "R4 search timeout", 0, 1);
    end
  endtask

  task automatic expectEnd(input string req, input bit expDone, input int v, input int b, input int w);
    check(done == expDone, req, done, expDone);
    check(fail == !expDone, req, fail, !expDone);
    check(int'(vcoSel) == v, req, vcoSel, v);
    check(int'(bandSel) == b, req, bandSel, b);
    check(wrCount == w, req, wrCount, w);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!wrReq && !done && !fail, "R1 flags", {wrReq, done, fail}, 0);
    check(vcoSel == 2'b01 && bandSel == 3'b000, "R1 sel", {vcoSel, bandSel}, 8);
    rstN = 1'b1;
    @(negedge clk);
    check(!wrReq && !done && !fail && vcoSel == 2'b01, "R1 after release", {wrReq, done, fail}, 0);

    runSearch(2, 3, 4, 0, 11);   expectEnd("R2 R4 immediate lock", 1, 2, 3, 1);
    runSearch(1, 6, 3, 0, 9);    expectEnd("R6 R7 up across VCO", 1, 2, 1, 4);
    runSearch(3, 0, 5, 0, 14);   expectEnd("R5 R7 down across VCO", 1, 2, 6, 3);
    runSearch(0, 2, 0, 0, 2);    expectEnd("R2 R11 zero VCO code", 1, 1, 2, 1);
    runSearch(1, 1, 2, 1, 0);    expectEnd("R8 bottom edge", 0, 1, 0, 2);
    runSearch(3, 6, 1, 2, 23);   expectEnd("R8 top edge", 0, 3, 7, 2);
    runSearch(2, 4, 3, 3, 0);    expectEnd("R9 reversal", 0, 2, 5, 2);
    runSearch(1, 0, 0, 0, 23);   expectEnd("R3 R7 full walk no settle", 1, 3, 7, 24);
    runSearch(3, 7, 12, 0, 16);  expectEnd("R3 long settle", 1, 3, 0, 8);

    // R10: start during a search is ignored; flags hold afterwards
    @(negedge clk);
    initVco = 2'd1; initBand = 3'd0; settleCycles = 16'd10;
    pMode = 0; pTarget = 20; wrCount = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    initVco = 2'd3; initBand = 3'd7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      if (done || fail) break;
      @(negedge clk);
    end
    expectEnd("R10 mid-search start ignored", 1, 3, 4, 21);
    repeat (10) @(negedge clk);
    check(done && !fail, "R10 done held", done, 1);
    check(wrCount == 21, "R10 no write after done", wrCount, 21);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    check(0, "R4 watchdog", cycles, 150000);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule